// File: doc/BRIEF.md
# Two-Slot Issue Packet Hazard Checker

This block sits in the decode stage of a statically scheduled, two-wide, in-order pipeline. Each cycle it receives one fetched packet of two 32-bit instruction words. The first slot may hold only an ALU or branch instruction, and the second slot may hold only a load or a store. The checker first confirms that each word fits its slot and that the packet address is aligned. It then looks for two kinds of dependency. The first is inside the packet: the second slot reads the register that the first slot writes. The second is against a load issued in the previous cycle, which has a use latency of one cycle.

From the result the checker decides each cycle whether to issue both slots, split the packet over two cycles, insert a one-cycle bubble, or drop an illegal packet. It tells fetch to hold the current packet while it is still working on it. The checker keeps its own record of the load now in execute. Reset clears that record.

Instruction encoding used by the checker: an all-zero word is a nop. Otherwise bits [31:30] give the class: 00 ALU (destination in [25:21], sources in [20:16] and [15:11]), 01 branch (sources in [20:16] and [15:11], no destination), 10 load (destination in [25:21], address base in [20:16]), 11 store (store data register in [25:21], address base in [20:16]).

Top module: `dual_issue_checker`

## Requirements
- R1: A valid packet whose three low address bits are not all zero (not 8-byte aligned) raises slot_err and issues neither slot, with fetch_stall low.
- R2: A valid packet with a load (class 10) or store (class 11) in slot 0, or an ALU (class 00) or branch (class 01) in slot 1, raises slot_err, issues neither slot and does not stall. A branch in slot 0 is legal.
- R3: The all-zero word is a nop, is legal in either slot, and creates no dependency.
- R4: A legal packet with no hazard issues both slots in the same cycle with fetch_stall low.
- R5: If slot 1 uses the register written by the slot 0 ALU instruction, either as its address base or as its store data, only slot 0 issues in the first cycle and fetch_stall is high. In the next cycle only slot 1 issues and fetch_stall is low.
- R6: If a load issued in the previous cycle writes a register that either slot of the current packet reads, nothing issues for one cycle with fetch_stall high, and the packet then proceeds normally. A packet that reads other registers is not delayed.
- R7: Register 0 is never a dependency source or destination: writing r0 or reading r0 causes neither a split nor a bubble.
- R8: While rst is high, no slot issues and fetch_stall is low. Reset also clears the record of a load in execute, so the first packet after reset sees no load-use hazard.
- R9: A cycle with pkt_valid low issues nothing, does not stall, and leaves no load in execute, so a packet that follows such a gap is not delayed by the earlier load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_addr_lo | input | 3 | Low bits of the packet's byte address |
| slot0_word | input | 32 | Instruction word for the ALU/branch slot |
| slot1_word | input | 32 | Instruction word for the load/store slot |
| issue_slot0 | output | 1 | Slot 0 instruction issues this cycle |
| issue_slot1 | output | 1 | Slot 1 instruction issues this cycle |
| fetch_stall | output | 1 | Fetch must hold the current packet |
| slot_err | output | 1 | Packet is misaligned or has a slot-class violation |

## Verification
The hardest state to reach is a packet that has both a load-use hazard against the previous packet and an intra-packet dependency. Such a packet must take a bubble, then the first half of a split, then the second half, in that order. The stimulus reaches this state by first issuing a load alone. It then holds a packet whose ALU slot reads the loaded register and whose store slot reads the ALU's result, and checks the outputs in each of the three cycles. A second hard case is showing that reset clears the record of the load. To cover it, the bench issues a load, pulses reset for one cycle, and then presents a packet that reads the load's destination.

// File: rtl/dipc_pkg.sv
package dipc_pkg;

    localparam int REG_W   = 5;
    localparam int WORD_W  = 32;
    localparam int CLS_HI  = 31;
    localparam int DST_LSB = 21;
    localparam int SRA_LSB = 16;
    localparam int SRB_LSB = 11;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        CLS_ALU = 2'b00,
        CLS_BR  = 2'b01,
        CLS_LD  = 2'b10,
        CLS_ST  = 2'b11
    } icls_e;

    typedef struct packed {
        icls_e    cls;
        logic     wr_en;
        reg_idx_t wr_reg;
        logic     src_a_en;
        reg_idx_t src_a;
        logic     src_b_en;
        reg_idx_t src_b;
    } slot_info_t;

    function automatic logic reads_reg(input slot_info_t s, input reg_idx_t r);
        return (s.src_a_en && (s.src_a == r)) || (s.src_b_en && (s.src_b == r));
    endfunction

endpackage

// File: rtl/dipc_slot_decode.sv
module dipc_slot_decode
    import dipc_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic [WORD_W-1:0] word,
    output slot_info_t        info,
    output logic              legal
);
    logic     is_nop;
    icls_e    cls;
    reg_idx_t f_dst, f_sa, f_sb;

    assign is_nop = (word == '0);
    assign cls    = icls_e'(word[CLS_HI -: 2]);
    assign f_dst  = word[DST_LSB +: REG_W];
    assign f_sa   = word[SRA_LSB +: REG_W];
    assign f_sb   = word[SRB_LSB +: REG_W];

    always_comb begin
        info          = '0;
        info.cls      = cls;
        if (!is_nop) begin
            unique case (cls)
                CLS_ALU: begin
                    info.wr_en    = (f_dst != '0);
                    info.wr_reg   = f_dst;
                    info.src_a_en = (f_sa != '0);
                    info.src_a    = f_sa;
                    info.src_b_en = (f_sb != '0);
                    info.src_b    = f_sb;
                end
                CLS_BR: begin
                    info.src_a_en = (f_sa != '0);
                    info.src_a    = f_sa;
                    info.src_b_en = (f_sb != '0);
                    info.src_b    = f_sb;
                end
                CLS_LD: begin
                    info.wr_en    = (f_dst != '0);
                    info.wr_reg   = f_dst;
                    info.src_a_en = (f_sa != '0);
                    info.src_a    = f_sa;
                end
                CLS_ST: begin
                    info.src_a_en = (f_sa != '0);
                    info.src_a    = f_sa;
                    info.src_b_en = (f_dst != '0);
                    info.src_b    = f_dst;
                end
                default: ;
            endcase
        end
    end

    generate
        if (SLOT == 0) begin : g_alu_slot
            assign legal = is_nop || (cls == CLS_ALU) || (cls == CLS_BR);
        end else begin : g_mem_slot
            assign legal = is_nop || (cls == CLS_LD) || (cls == CLS_ST);
        end
    endgenerate

endmodule

// File: rtl/dipc_hazard.sv
module dipc_hazard
    import dipc_pkg::*;
(
    input  slot_info_t s0,
    input  slot_info_t s1,
    input  logic       ld_pend,
    input  reg_idx_t   ld_reg,
    output logic       intra_dep,
    output logic       ld_use,
    output logic       s1_ld_en,
    output reg_idx_t   s1_ld_reg
);
    assign intra_dep = (s0.cls == CLS_ALU) && s0.wr_en && reads_reg(s1, s0.wr_reg);
    assign ld_use    = ld_pend && (reads_reg(s0, ld_reg) || reads_reg(s1, ld_reg));
    assign s1_ld_en  = (s1.cls == CLS_LD) && s1.wr_en;
    assign s1_ld_reg = s1.wr_reg;
endmodule

// File: rtl/dipc_issue_ctrl.sv
module dipc_issue_ctrl
    import dipc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pkt_valid,
    input  logic     pkt_err,
    input  logic     intra_dep,
    input  logic     ld_use,
    input  logic     s1_ld_en,
    input  reg_idx_t s1_ld_reg,
    output logic     iss0,
    output logic     iss1,
    output logic     stall,
    output logic     ld_pend,
    output reg_idx_t ld_reg
);
    typedef enum logic {ST_WHOLE, ST_SECOND} phase_e;

    phase_e phase_q, phase_d;

    always_comb begin
        iss0    = 1'b0;
        iss1    = 1'b0;
        stall   = 1'b0;
        phase_d = phase_q;
        if (rst) begin
            phase_d = ST_WHOLE;
        end else if (phase_q == ST_SECOND) begin
            if (pkt_valid) begin
                iss1    = 1'b1;
                phase_d = ST_WHOLE;
            end else begin
                stall = 1'b1;
            end
        end else if (pkt_valid && !pkt_err) begin
            if (ld_use) begin
                stall = 1'b1;
            end else if (intra_dep) begin
                iss0    = 1'b1;
                stall   = 1'b1;
                phase_d = ST_SECOND;
            end else begin
                iss0 = 1'b1;
                iss1 = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_WHOLE;
            ld_pend <= 1'b0;
            ld_reg  <= '0;
        end else begin
            phase_q <= phase_d;
            ld_pend <= iss1 && s1_ld_en;
            ld_reg  <= s1_ld_reg;
        end
    end

endmodule

// File: rtl/dual_issue_checker.sv
module dual_issue_checker
    import dipc_pkg::*;
#(
    parameter int ALIGN_BYTES = 8,
    localparam int ALIGN_LSB  = $clog2(ALIGN_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pkt_valid,
    input  logic [ALIGN_LSB-1:0] pkt_addr_lo,
    input  logic [WORD_W-1:0]    slot0_word,
    input  logic [WORD_W-1:0]    slot1_word,
    output logic                 issue_slot0,
    output logic                 issue_slot1,
    output logic                 fetch_stall,
    output logic                 slot_err
);
    localparam int NSLOT = 2;

    logic [WORD_W-1:0] words [NSLOT];
    slot_info_t        info  [NSLOT];
    logic [NSLOT-1:0]  legal;
    logic              misaligned, intra_dep, ld_use, s1_ld_en, ld_pend;
    reg_idx_t          s1_ld_reg, ld_reg;

    assign words[0] = slot0_word;
    assign words[1] = slot1_word;

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_dec
            dipc_slot_decode #(.SLOT(i)) u_dec (
                .word  (words[i]),
                .info  (info[i]),
                .legal (legal[i])
            );
        end
    endgenerate

    assign misaligned = (pkt_addr_lo != '0);
    assign slot_err   = !rst && pkt_valid && (misaligned || !(&legal));

    dipc_hazard u_haz (
        .s0        (info[0]),
        .s1        (info[1]),
        .ld_pend   (ld_pend),
        .ld_reg    (ld_reg),
        .intra_dep (intra_dep),
        .ld_use    (ld_use),
        .s1_ld_en  (s1_ld_en),
        .s1_ld_reg (s1_ld_reg)
    );

    dipc_issue_ctrl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .pkt_valid (pkt_valid),
        .pkt_err   (slot_err),
        .intra_dep (intra_dep),
        .ld_use    (ld_use),
        .s1_ld_en  (s1_ld_en),
        .s1_ld_reg (s1_ld_reg),
        .iss0      (issue_slot0),
        .iss1      (issue_slot1),
        .stall     (fetch_stall),
        .ld_pend   (ld_pend),
        .ld_reg    (ld_reg)
    );

endmodule

// File: rtl/dual_issue_checker_sva.sv
module dual_issue_checker_sva (
    input logic clk,
    input logic rst,
    input logic pkt_valid,
    input logic issue_slot0,
    input logic issue_slot1,
    input logic fetch_stall,
    input logic slot_err
);
    p_err_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        slot_err |-> (!issue_slot0 && !issue_slot1));

    p_err_nostall_r1: assert property (@(posedge clk) disable iff (rst)
        slot_err |-> !fetch_stall);

    p_split_second_r5: assert property (@(posedge clk) disable iff (rst)
        (issue_slot0 && !issue_slot1) |=> (!pkt_valid || (issue_slot1 && !issue_slot0)));

    p_lone_slot1_r5: assert property (@(posedge clk) disable iff (rst)
        (issue_slot1 && !issue_slot0) |-> $past(issue_slot0 && !issue_slot1));

    p_bubble_once_r6: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && fetch_stall && !issue_slot0 && !issue_slot1)
        |=> (!pkt_valid || issue_slot0));

endmodule

bind dual_issue_checker dual_issue_checker_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .pkt_valid   (pkt_valid),
    .issue_slot0 (issue_slot0),
    .issue_slot1 (issue_slot1),
    .fetch_stall (fetch_stall),
    .slot_err    (slot_err)
);

// File: tb/sim_dual_issue_checker.sv
module sim_dual_issue_checker;

    logic        clk = 1'b0;
    logic        rst;
    logic        pkt_valid;
    logic [2:0]  pkt_addr_lo;
    logic [31:0] slot0_word, slot1_word;
    logic        issue_slot0, issue_slot1, fetch_stall, slot_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dual_issue_checker u0 (
        .clk         (clk),
        .rst         (rst),
        .pkt_valid   (pkt_valid),
        .pkt_addr_lo (pkt_addr_lo),
        .slot0_word  (slot0_word),
        .slot1_word  (slot1_word),
        .issue_slot0 (issue_slot0),
        .issue_slot1 (issue_slot1),
        .fetch_stall (fetch_stall),
        .slot_err    (slot_err)
    );

    localparam logic [31:0] NOP = 32'h0;

    function automatic logic [31:0] w_alu(input logic [4:0] rd, input logic [4:0] a, input logic [4:0] b);
        return {2'b00, 4'b0, rd, a, b, 11'b0};
    endfunction
    function automatic logic [31:0] w_br(input logic [4:0] a, input logic [4:0] b);
        return {2'b01, 4'b0, 5'b0, a, b, 11'b0};
    endfunction
    function automatic logic [31:0] w_ld(input logic [4:0] rd, input logic [4:0] base);
        return {2'b10, 4'b0, rd, base, 16'b0};
    endfunction
    function automatic logic [31:0] w_st(input logic [4:0] data, input logic [4:0] base);
        return {2'b11, 4'b0, data, base, 16'b0};
    endfunction

    // Drive at the falling edge, sample 1 ns later; the next rising edge commits.
    // Expected vector is {issue_slot0, issue_slot1, fetch_stall, slot_err}.
    task automatic step(input logic v, input logic [2:0] lo, input logic [31:0] a,
                        input logic [31:0] b, input logic [3:0] exp, input string tag);
        @(negedge clk);
        pkt_valid   = v;
        pkt_addr_lo = lo;
        slot0_word  = a;
        slot1_word  = b;
        #1;
        checks++;
        if ({issue_slot0, issue_slot1, fetch_stall, slot_err} !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag,
                     {issue_slot0, issue_slot1, fetch_stall, slot_err}, exp);
        end
    endtask

    task automatic idle();
        step(1'b0, 3'd0, NOP, NOP, 4'b0000, "R9 idle");
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        step(1'b1, 3'd0, w_alu(1, 2, 3), w_ld(4, 5), 4'b0000, "R8 outputs quiet in reset");
        step(1'b1, 3'd0, w_alu(1, 2, 3), w_ld(4, 5), 4'b0000, "R8 outputs quiet in reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_clean_and_gap();
        step(1'b1, 3'd0, w_alu(1, 2, 3), w_ld(4, 5), 4'b1100, "R4 clean pair");
        step(1'b0, 3'd0, NOP, NOP, 4'b0000, "R9 invalid cycle");
        step(1'b1, 3'd0, w_alu(6, 4, 0), NOP, 4'b1100, "R9 gap clears load");
    endtask

    task automatic t_nops();
        step(1'b1, 3'd0, NOP, NOP, 4'b1100, "R3 nop both slots");
        step(1'b1, 3'd0, w_alu(1, 2, 3), NOP, 4'b1100, "R3 nop slot1");
        step(1'b1, 3'd0, NOP, w_st(7, 8), 4'b1100, "R3 nop slot0");
    endtask

    task automatic t_intra();
        step(1'b1, 3'd0, w_alu(9, 1, 2), w_ld(3, 9), 4'b1010, "R5 base dep first half");
        step(1'b1, 3'd0, w_alu(9, 1, 2), w_ld(3, 9), 4'b0100, "R5 base dep second half");
        idle();
        step(1'b1, 3'd0, w_alu(9, 1, 2), w_st(9, 1), 4'b1010, "R5 data dep first half");
        step(1'b1, 3'd0, w_alu(9, 1, 2), w_st(9, 1), 4'b0100, "R5 data dep second half");
    endtask

    task automatic t_reg0();
        step(1'b1, 3'd0, w_alu(0, 1, 2), w_ld(3, 0), 4'b1100, "R7 alu writes r0");
        idle();
        step(1'b1, 3'd0, NOP, w_ld(0, 5), 4'b1100, "R7 load to r0");
        step(1'b1, 3'd0, w_alu(1, 0, 0), w_st(0, 2), 4'b1100, "R7 reads r0 after load r0");
    endtask

    task automatic t_load_use();
        step(1'b1, 3'd0, NOP, w_ld(10, 1), 4'b1100, "R6 load issue");
        step(1'b1, 3'd0, w_alu(2, 10, 3), NOP, 4'b0010, "R6 slot0 reads load: bubble");
        step(1'b1, 3'd0, w_alu(2, 10, 3), NOP, 4'b1100, "R6 after bubble");
        step(1'b1, 3'd0, NOP, w_ld(11, 1), 4'b1100, "R6 load issue");
        step(1'b1, 3'd0, NOP, w_st(11, 5), 4'b0010, "R6 slot1 reads load: bubble");
        step(1'b1, 3'd0, NOP, w_st(11, 5), 4'b1100, "R6 after bubble");
        step(1'b1, 3'd0, NOP, w_ld(12, 1), 4'b1100, "R6 load issue");
        step(1'b1, 3'd0, w_alu(3, 4, 5), w_ld(6, 7), 4'b1100, "R6 unrelated no bubble");
    endtask

    task automatic t_bubble_then_split();
        idle();
        step(1'b1, 3'd0, NOP, w_ld(13, 1), 4'b1100, "R6 load issue");
        step(1'b1, 3'd0, w_alu(14, 13, 0), w_st(14, 2), 4'b0010, "R6 bubble before split");
        step(1'b1, 3'd0, w_alu(14, 13, 0), w_st(14, 2), 4'b1010, "R5 split first after bubble");
        step(1'b1, 3'd0, w_alu(14, 13, 0), w_st(14, 2), 4'b0100, "R5 split second after bubble");
    endtask

    task automatic t_slot_class();
        step(1'b1, 3'd0, w_ld(1, 2), NOP, 4'b0001, "R2 load in slot0");
        step(1'b1, 3'd0, w_st(1, 2), NOP, 4'b0001, "R2 store in slot0");
        step(1'b1, 3'd0, NOP, w_alu(1, 2, 3), 4'b0001, "R2 alu in slot1");
        step(1'b1, 3'd0, NOP, w_br(1, 2), 4'b0001, "R2 branch in slot1");
        step(1'b1, 3'd0, w_br(1, 2), w_st(3, 4), 4'b1100, "R2 branch in slot0 legal");
    endtask

    task automatic t_align();
        step(1'b1, 3'd4, w_alu(1, 2, 3), w_ld(4, 5), 4'b0001, "R1 offset 4");
        step(1'b1, 3'd1, w_alu(1, 2, 3), NOP, 4'b0001, "R1 offset 1");
        idle();
        step(1'b1, 3'd0, w_alu(1, 2, 3), w_ld(4, 5), 4'b1100, "R1 aligned");
    endtask

    task automatic t_reset_clears();
        idle();
        step(1'b1, 3'd0, NOP, w_ld(15, 1), 4'b1100, "R8 load before reset");
        @(negedge clk);
        rst = 1'b1;
        step(1'b1, 3'd0, w_alu(1, 15, 0), NOP, 4'b0000, "R8 quiet during reset");
        @(negedge clk);
        rst = 1'b0;
        #1;
        checks++;
        if ({issue_slot0, issue_slot1, fetch_stall, slot_err} !== 4'b1100) begin
            errors++;
            $display("FAIL R8 first packet after reset: got %b expected %b",
                     {issue_slot0, issue_slot1, fetch_stall, slot_err}, 4'b1100);
        end
    endtask

    initial begin
        rst         = 1'b1;
        pkt_valid   = 1'b0;
        pkt_addr_lo = '0;
        slot0_word  = '0;
        slot1_word  = '0;
        t_reset();
        t_clean_and_gap();
        t_nops();
        t_intra();
        idle();
        t_reg0();
        t_load_use();
        t_bubble_then_split();
        t_slot_class();
        t_align();
        t_reset_clears();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule